// File: doc/BRIEF.md
# Floating-Point Status and Compare-Flag Unit

This block holds the floating-point status word and updates it from the results of floating-point operations. The arithmetic datapath reports a group of five IEEE exception flags. The unit copies them into the current-exception field. When one of those flags is enabled to trap, the unit records a trap type and pulses a trap request. When none is enabled, it folds the flags into the sticky accrued-exception field.

Compare results arrive as a two-bit relation code. A selector picks one of four two-bit condition-code slots to receive the code. A compare that returns unordered either raises an invalid-operation trap or marks invalid as accrued. Which one happens depends on the invalid trap-enable bit and on whether the compare is the signaling kind. The unit also decodes the two-bit rounding-direction field into a one-hot rounding-mode output for the datapath. Software can overwrite the whole word, and a software write wins over any hardware update in the same cycle.

Top module: `fpsu_top`

## Requirements
- R1: After reset, the status word is all zeros, `trap_req` is low and `round_mode` is 4'b0001.
- R2: On `op_valid`, bits 4:0 take `op_flags`. The flag order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0. If `op_flags` ANDed with the enable field (bits 27:23, same order) is zero, the accrued field (bits 9:5) is ORed with `op_flags` and no trap is raised.
- R3: On `op_valid` with at least one enabled flag, bits 4:0 take `op_flags`, bits 9:5 are unchanged, and the trap-kind field (bits 16:14) becomes 3'd1. `trap_req` is then high for exactly the one cycle after the update edge.
- R4: A compare clears its selected two-bit slot and then writes the relation. The relation code is 0 equal, 1 less, 2 greater, 3 unordered. Unordered gives 2'b11, less gives 2'b01, greater gives 2'b10 and equal gives 2'b00. The other slots are not changed.
- R5: `cmp_sel` 0 selects bits 11:10, 1 selects bits 33:32, 2 selects bits 35:34 and 3 selects bits 37:36.
- R6: An unordered quiet compare (`cmp_signal` 0) with invalid-enable bit 27 clear sets accrued invalid (bit 9). It leaves bits 4:0 and the trap-kind field unchanged and raises no trap.
- R7: An unordered compare that is signaling, or that sees bit 27 set, sets bit 4, writes trap kind 3'd1 and pulses `trap_req`. Bits 3:0 and the accrued field keep their values.
- R8: `round_mode` is one-hot from bits 31:30. Value 0 gives bit 0 (nearest-even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward +infinity) and 3 gives bit 3 (toward -infinity).
- R9: When `sw_we` is high, the word takes `sw_wdata` at that edge and no trap is raised, whatever the operation and compare inputs are.
- R10: While `trap_req` is high, `op_valid` and `cmp_valid` are ignored: the word does not change and no new trap is raised.
- R11: If `op_valid` and `cmp_valid` are high together, only the operation update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 38 | Software write data |
| op_valid | input | 1 | An arithmetic result's flags are present |
| op_flags | input | 5 | IEEE exception flags of that result |
| cmp_valid | input | 1 | A compare result is present |
| cmp_rel | input | 2 | Relation code (0 eq, 1 lt, 2 gt, 3 unordered) |
| cmp_sel | input | 2 | Condition-code slot select |
| cmp_signal | input | 1 | Compare is the signaling kind |
| stat_q | output | 38 | Status word |
| trap_req | output | 1 | One-cycle trap request |
| round_mode | output | 4 | One-hot rounding mode |

## Verification
Every update registers at the clock edge that samples its inputs, so `stat_q` carries the new value straight after that edge. `round_mode` follows the register through combinational logic in that same cycle. `trap_req` comes from its own flop, so it is high in the cycle after the sampling edge and must be low again one cycle later. The bench drives inputs on the falling edge and samples on the next falling edge after the update. It then waits one more cycle and checks that the trap pulse has ended.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int FLAG_W   = 5;
  localparam int NUM_CC   = 4;
  localparam int SEL_W    = $clog2(NUM_CC);
  localparam int CUR_LSB  = 0;
  localparam int ACC_LSB  = CUR_LSB + FLAG_W;
  localparam int CC0_LSB  = 10;
  localparam int KIND_LSB = 14;
  localparam int KIND_W   = 3;
  localparam int ENA_LSB  = 23;
  localparam int RND_LSB  = 30;
  localparam int RND_W    = 2;
  localparam int NUM_RND  = 1 << RND_W;
  localparam int CCX_LSB  = CC0_LSB + 22;
  localparam int STAT_W   = CCX_LSB + 2 * (NUM_CC - 1);
  localparam int NV_BIT   = FLAG_W - 1;

  localparam logic [KIND_W-1:0] KIND_IEEE = 3'd1;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  function automatic int cc_lsb(input int idx);
    return (idx == 0) ? CC0_LSB : CCX_LSB + 2 * (idx - 1);
  endfunction
endpackage

// File: rtl/fpsu_exc.sv
module fpsu_exc
  import fpsu_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              fire_o
);
  logic [FLAG_W-1:0] ena;
  assign ena    = stat_i[ENA_LSB +: FLAG_W];
  assign fire_o = |(flags_i & ena);

  always_comb begin
    stat_o = stat_i;
    stat_o[CUR_LSB +: FLAG_W] = flags_i;
    if (fire_o) begin
      stat_o[KIND_LSB +: KIND_W] = KIND_IEEE;
    end else begin
      stat_o[ACC_LSB +: FLAG_W] = stat_i[ACC_LSB +: FLAG_W] | flags_i;
    end
  end
endmodule

// File: rtl/fpsu_cmp.sv
module fpsu_cmp
  import fpsu_pkg::*;
(
  input  logic [STAT_W-1:0] stat_i,
  input  logic [1:0]        rel_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              signal_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              fire_o
);
  rel_e       rel;
  logic [1:0] pair;
  logic       unord;

  assign rel   = rel_e'(rel_i);
  assign unord = (rel == REL_UN);

  always_comb begin
    unique case (rel)
      REL_UN:  pair = 2'b11;
      REL_LT:  pair = 2'b01;
      REL_GT:  pair = 2'b10;
      default: pair = 2'b00;
    endcase
  end

  assign fire_o = unord & (stat_i[ENA_LSB + NV_BIT] | signal_i);

  always_comb begin
    stat_o = stat_i;
    for (int i = 0; i < NUM_CC; i++) begin
      if (sel_i == SEL_W'(i)) stat_o[cc_lsb(i) +: 2] = pair;
    end
    if (unord) begin
      if (fire_o) begin
        stat_o[CUR_LSB + NV_BIT]   = 1'b1;
        stat_o[KIND_LSB +: KIND_W] = KIND_IEEE;
      end else begin
        stat_o[ACC_LSB + NV_BIT] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpsu_rnd.sv
module fpsu_rnd
  import fpsu_pkg::*;
(
  input  logic [RND_W-1:0]   rd_i,
  output logic [NUM_RND-1:0] mode_o
);
  for (genvar g = 0; g < NUM_RND; g++) begin : g_mode
    assign mode_o[g] = (rd_i == RND_W'(g));
  end
endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
  import fpsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              op_valid,
  input  logic [FLAG_W-1:0] op_flags,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_rel,
  input  logic [SEL_W-1:0]  cmp_sel,
  input  logic              cmp_signal,
  output logic [STAT_W-1:0] stat_q,
  output logic              trap_req,
  output logic [NUM_RND-1:0] round_mode
);
  logic [1:0]        rst_sync_q;
  logic              rst_ok;
  logic [STAT_W-1:0] stat_r, stat_d, exc_stat, cmp_stat;
  logic              stat_en, trap_r, trap_d, exc_fire, cmp_fire;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  fpsu_exc u_exc (
    .stat_i (stat_r),
    .flags_i(op_flags),
    .stat_o (exc_stat),
    .fire_o (exc_fire)
  );

  fpsu_cmp u_cmp (
    .stat_i  (stat_r),
    .rel_i   (cmp_rel),
    .sel_i   (cmp_sel),
    .signal_i(cmp_signal),
    .stat_o  (cmp_stat),
    .fire_o  (cmp_fire)
  );

  fpsu_rnd u_rnd (
    .rd_i  (stat_r[RND_LSB +: RND_W]),
    .mode_o(round_mode)
  );

  always_comb begin
    stat_d  = stat_r;
    stat_en = 1'b0;
    trap_d  = 1'b0;
    if (sw_we) begin
      stat_d  = sw_wdata;
      stat_en = 1'b1;
    end else if (!trap_r) begin
      if (op_valid) begin
        stat_d  = exc_stat;
        stat_en = 1'b1;
        trap_d  = exc_fire;
      end else if (cmp_valid) begin
        stat_d  = cmp_stat;
        stat_en = 1'b1;
        trap_d  = cmp_fire;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      stat_r <= '0;
      trap_r <= 1'b0;
    end else begin
      trap_r <= trap_d;
      if (stat_en) stat_r <= stat_d;
    end
  end

  assign stat_q   = stat_r;
  assign trap_req = trap_r;
endmodule

// File: rtl/fpsu_chk.sv
module fpsu_chk
  import fpsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [STAT_W-1:0] sw_wdata,
  input logic              op_valid,
  input logic              cmp_valid,
  input logic [1:0]        cmp_rel,
  input logic [SEL_W-1:0]  cmp_sel,
  input logic [STAT_W-1:0] stat_q,
  input logic              trap_req,
  input logic [NUM_RND-1:0] round_mode
);
  // R3
  trap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  // R3
  trap_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (stat_q[KIND_LSB +: KIND_W] == KIND_IEEE));

  // R9
  sw_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (stat_q == $past(sw_wdata)));

  // R10
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !sw_we) |=> $stable(stat_q));

  // R8
  round_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(round_mode) == 1);

  // R2
  accrued_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((stat_q[ACC_LSB +: FLAG_W] & $past(stat_q[ACC_LSB +: FLAG_W]))
                == $past(stat_q[ACC_LSB +: FLAG_W])));

  // R4
  equal_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !op_valid && !sw_we && !trap_req && cmp_sel == '0 &&
     cmp_rel == 2'd0) |=> (stat_q[CC0_LSB +: 2] == 2'b00));
endmodule

bind fpsu_top fpsu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ok),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .op_valid  (op_valid),
  .cmp_valid (cmp_valid),
  .cmp_rel   (cmp_rel),
  .cmp_sel   (cmp_sel),
  .stat_q    (stat_q),
  .trap_req  (trap_req),
  .round_mode(round_mode)
);

// File: tb/sim_fpsu_top.sv
module sim_fpsu_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 38;

  typedef struct packed {
    logic [W-1:0] pre;
    logic         is_cmp;
    logic [4:0]   flags;
    logic [1:0]   rel;
    logic [1:0]   sel;
    logic         sig;
    logic [W-1:0] exp;
    logic         exp_trap;
  } vec_t;

  localparam logic [W-1:0] ONE = 38'd1;

  localparam vec_t VECS [12] = '{
    // R2 plain inexact accrues
    '{38'd0, 1'b0, 5'b00001, 2'd0, 2'd0, 1'b0, 38'h21, 1'b0},
    // R2 current replaced, accrued ORed
    '{(38'd16 << 5) | 38'd6, 1'b0, 5'b01000, 2'd0, 2'd0, 1'b0,
      (38'd24 << 5) | 38'd8, 1'b0},
    // R3 enabled overflow traps
    '{ONE << 26, 1'b0, 5'b01001, 2'd0, 2'd0, 1'b0,
      (ONE << 26) | (ONE << 14) | 38'd9, 1'b1},
    // R2 flag not enabled accrues
    '{ONE << 23, 1'b0, 5'b10000, 2'd0, 2'd0, 1'b0,
      (ONE << 23) | 38'd16 | (38'd16 << 5), 1'b0},
    // R4 less on slot 0
    '{38'd0, 1'b1, 5'd0, 2'd1, 2'd0, 1'b0, ONE << 10, 1'b0},
    // R4 greater clears old pair
    '{38'd3 << 10, 1'b1, 5'd0, 2'd2, 2'd0, 1'b0, 38'd2 << 10, 1'b0},
    // R4 R5 equal clears slot 0 only
    '{(38'd3 << 10) | (38'd3 << 32), 1'b1, 5'd0, 2'd0, 2'd0, 1'b0,
      38'd3 << 32, 1'b0},
    // R5 R6 quiet unordered on slot 1 accrues invalid
    '{38'd0, 1'b1, 5'd0, 2'd3, 2'd1, 1'b0, (38'd3 << 32) | (ONE << 9), 1'b0},
    // R5 less on slot 2, slot 3 untouched
    '{38'd3 << 36, 1'b1, 5'd0, 2'd1, 2'd2, 1'b0,
      (ONE << 34) | (38'd3 << 36), 1'b0},
    // R5 greater on slot 3
    '{ONE << 36, 1'b1, 5'd0, 2'd2, 2'd3, 1'b0, 38'd2 << 36, 1'b0},
    // R7 signaling unordered traps
    '{38'd0, 1'b1, 5'd0, 2'd3, 2'd0, 1'b1,
      (38'd3 << 10) | 38'd16 | (ONE << 14), 1'b1},
    // R7 quiet unordered with invalid enabled traps
    '{(ONE << 27) | 38'd2, 1'b1, 5'd0, 2'd3, 2'd3, 1'b0,
      (ONE << 27) | 38'd18 | (ONE << 14) | (38'd3 << 36), 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sw_we, op_valid, cmp_valid, cmp_signal;
  logic [W-1:0] sw_wdata;
  logic [4:0]   op_flags;
  logic [1:0]   cmp_rel, cmp_sel;
  logic [W-1:0] stat_q;
  logic         trap_req;
  logic [3:0]   round_mode;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpsu_top u0 (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .op_valid(op_valid), .op_flags(op_flags), .cmp_valid(cmp_valid),
    .cmp_rel(cmp_rel), .cmp_sel(cmp_sel), .cmp_signal(cmp_signal),
    .stat_q(stat_q), .trap_req(trap_req), .round_mode(round_mode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [W-1:0] d);
    sw_we = 1'b1; sw_wdata = d;
    step();
    sw_we = 1'b0;
  endtask

  task automatic idle();
    op_valid = 1'b0; cmp_valid = 1'b0; sw_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_we = 0; sw_wdata = '0; op_valid = 0; op_flags = '0;
    cmp_valid = 0; cmp_rel = '0; cmp_sel = '0; cmp_signal = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1
    chk("R1 status", 64'(stat_q), 64'd0);
    chk("R1 trap", 64'(trap_req), 64'd0);
    chk("R1 round", 64'(round_mode), 64'd1);

    for (int i = 0; i < 12; i++) begin
      sw_write(VECS[i].pre);
      if (VECS[i].is_cmp) begin
        cmp_valid = 1'b1; cmp_rel = VECS[i].rel;
        cmp_sel = VECS[i].sel; cmp_signal = VECS[i].sig;
      end else begin
        op_valid = 1'b1; op_flags = VECS[i].flags;
      end
      step();
      idle();
      chk($sformatf("vector %0d status", i), 64'(stat_q), 64'(VECS[i].exp));
      chk($sformatf("vector %0d trap", i), 64'(trap_req), 64'(VECS[i].exp_trap));
      step();
      // R3 pulse lasts one cycle
      chk($sformatf("vector %0d trap end R3", i), 64'(trap_req), 64'd0);
    end

    // R8 rounding decode
    for (int r = 0; r < 4; r++) begin
      sw_write(38'(r) << 30);
      chk($sformatf("R8 rd=%0d", r), 64'(round_mode), 64'(4'b0001 << r));
    end

    // R9 software write beats an enabled exception
    sw_write(38'h1F << 23);
    sw_we = 1'b1; sw_wdata = (38'd2 << 30) | 38'd3;
    op_valid = 1'b1; op_flags = 5'h1F;
    step();
    idle();
    chk("R9 status", 64'(stat_q), 64'((38'd2 << 30) | 38'd3));
    chk("R9 trap", 64'(trap_req), 64'd0);
    chk("R9 round", 64'(round_mode), 64'd4);

    // R10 inputs during the trap cycle are dropped
    sw_write(38'h1F << 23);
    op_valid = 1'b1; op_flags = 5'b00001;
    step();
    chk("R10 trap set", 64'(trap_req), 64'd1);
    op_flags = 5'b00100; cmp_valid = 1'b1; cmp_rel = 2'd3; cmp_sel = 2'd0;
    cmp_signal = 1'b1;
    step();
    idle();
    chk("R10 status held", 64'(stat_q),
        64'((38'h1F << 23) | (ONE << 14) | 38'd1));
    chk("R10 no new trap", 64'(trap_req), 64'd0);

    // R11 operation wins over compare
    sw_write(38'd0);
    op_valid = 1'b1; op_flags = 5'b00010;
    cmp_valid = 1'b1; cmp_rel = 2'd1; cmp_sel = 2'd0; cmp_signal = 1'b0;
    step();
    idle();
    chk("R11 status", 64'(stat_q), 64'(38'd2 | (38'd2 << 5)));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule